// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block expands one multi-register memory transfer into a stream of single-word accesses. A request carries a base address, a 16-bit mask that selects registers, one of four address orderings, a direction flag (load or store) and a flag that asks for the base register to be updated. The request is taken on a valid/ready handshake. For every set bit of the mask the block then offers one transfer, made of a register index and a word address, on a second valid/ready handshake. The lowest-numbered register always lands at the lowest address, whatever the ordering.

The four orderings choose whether addresses climb or fall from the base and whether the base itself is the first word touched. With N selected registers, the first address is the base (climb, use then step), base+4 (climb, step then use), base-4N+4 (fall, use then step) or base-4N (fall, step then use). Each later transfer is 4 above the one before. When the last transfer has been accepted, the block gives a one-cycle completion strobe. The strobe carries the new base value, which is base+4N when climbing and base-4N when falling, together with an enable that is set only if the request asked for the base update. Register file and memory sit outside the block and follow these handshakes.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset `req_ready` is 1, `xfer_valid` is 0 and `fin_valid` is 0. A request is accepted only while `req_ready` is 1. `req_ready` stays 0 from the cycle after acceptance until the cycle after `fin_valid`.
- R2: An accepted request produces exactly one accepted transfer for each set bit of `req_mask`. The transfers come in ascending register index, and `xfer_reg` gives the bit position.
- R3: Mode 0 (climb, use then step): the first transfer address equals the base.
- R4: Mode 1 (climb, step then use): the first transfer address is base+4.
- R5: Mode 2 (fall, use then step): the first transfer address is base-4N+4, where N is the number of set mask bits.
- R6: Mode 3 (fall, step then use): the first transfer address is base-4N.
- R7: Each transfer after the first has an address exactly 4 above the previous transfer of the same request.
- R8: While `xfer_valid` is 1 and `xfer_ready` is 0, the next cycle keeps `xfer_valid` at 1 and leaves `xfer_reg` and `xfer_addr` unchanged.
- R9: `fin_valid` is 1 for exactly one cycle, in the cycle after the last transfer is accepted. In that cycle `fin_base` is base+4N for modes 0 and 1 and base-4N for modes 2 and 3, and `fin_wb_en` equals the request's `req_wb` bit.
- R10: `xfer_load` on every transfer equals the `req_load` bit of its request (1 = load, 0 = store).
- R11: A request with an all-zero mask produces no transfer. `fin_valid` rises in the cycle after acceptance, with `fin_base` equal to the base.
- R12: All address arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_base | input | 32 | Base register value |
| req_mask | input | 16 | Register selection, bit i selects register i |
| req_mode | input | 2 | Ordering: 0 climb/use-step, 1 climb/step-use, 2 fall/use-step, 3 fall/step-use |
| req_load | input | 1 | 1 load, 0 store |
| req_wb | input | 1 | Update base register at the end |
| xfer_valid | output | 1 | Transfer offered |
| xfer_ready | input | 1 | Transfer taken by the memory side |
| xfer_reg | output | 4 | Register index of this transfer |
| xfer_addr | output | 32 | Word address of this transfer |
| xfer_load | output | 1 | Direction of this transfer |
| fin_valid | output | 1 | One-cycle completion strobe |
| fin_base | output | 32 | New base value |
| fin_wb_en | output | 1 | Write the new base back |

## Verification
The bench aims at the falling orderings with full, single-bit and sparse masks. A sequencer that skipped the 4N correction, or that walked registers from the top down, would put the lowest register at the wrong address there. It also runs requests whose addresses wrap across zero in both directions, an empty mask, and a memory side that stalls at random. A design that advanced while stalled would drop or repeat a register, and one that counted the empty mask wrongly would hang or strobe completion late. Every completion strobe is checked against the exact cycle after the final accepted transfer, so a strobe that is early, late or two cycles wide is reported.

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int ADDR_W     = 32,
  parameter int NREG       = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_base,
  input  logic [NREG-1:0]          req_mask,
  input  logic [1:0]               req_mode,
  input  logic                     req_load,
  input  logic                     req_wb,
  output logic                     xfer_valid,
  input  logic                     xfer_ready,
  output logic [$clog2(NREG)-1:0]  xfer_reg,
  output logic [ADDR_W-1:0]        xfer_addr,
  output logic                     xfer_load,
  output logic                     fin_valid,
  output logic [ADDR_W-1:0]        fin_base,
  output logic                     fin_wb_en
);
  localparam int IDX_W = $clog2(NREG);
  localparam int CNT_W = $clog2(NREG + 1);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_MOVE, S_FIN} st_t;

  st_t               st;
  logic [NREG-1:0]   pend;
  logic [ADDR_W-1:0] addr_q, fin_q;
  logic              load_q, wb_q;

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] span, first_addr, end_base;
  logic [IDX_W-1:0]  low_idx;
  logic [NREG-1:0]   pend_nxt;
  logic              take_req, take_xfer;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREG; i++) cnt = cnt + CNT_W'(req_mask[i]);
  end

  assign span = ADDR_W'(cnt) * STEP;

  // mode bit 1: falling addresses; mode bit 0: step before first use
  always_comb begin
    case (req_mode)
      2'd0:    first_addr = req_base;
      2'd1:    first_addr = req_base + STEP;
      2'd2:    first_addr = req_base - span + STEP;
      default: first_addr = req_base - span;
    endcase
  end

  assign end_base = req_mode[1] ? (req_base - span) : (req_base + span);

  always_comb begin
    low_idx = '0;
    for (int i = NREG - 1; i >= 0; i--) if (pend[i]) low_idx = IDX_W'(i);
  end

  assign pend_nxt  = pend & ~(NREG'(1) << low_idx);
  assign take_req  = req_valid && req_ready;
  assign take_xfer = xfer_valid && xfer_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pend   <= '0;
      addr_q <= '0;
      fin_q  <= '0;
      load_q <= 1'b0;
      wb_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take_req) begin
          pend   <= req_mask;
          addr_q <= first_addr;
          fin_q  <= end_base;
          load_q <= req_load;
          wb_q   <= req_wb;
          st     <= (req_mask == '0) ? S_FIN : S_MOVE;
        end
        S_MOVE: if (take_xfer) begin
          pend   <= pend_nxt;
          addr_q <= addr_q + STEP;
          if (pend_nxt == '0) st <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign xfer_valid = (st == S_MOVE);
  assign xfer_reg   = low_idx;
  assign xfer_addr  = addr_q;
  assign xfer_load  = load_q;
  assign fin_valid  = (st == S_FIN);
  assign fin_base   = fin_q;
  assign fin_wb_en  = wb_q;

  AST_REQ_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |=> !req_ready); // R1

  AST_REG_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    take_xfer |=> (!xfer_valid || xfer_reg > $past(xfer_reg))); // R2

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    take_xfer |=> (!xfer_valid || xfer_addr == $past(xfer_addr) + STEP)); // R7

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_reg) && $stable(xfer_addr))); // R8

  AST_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fin_valid |=> !fin_valid); // R9

  AST_NO_XFER_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!xfer_valid && !fin_valid)); // R1
endmodule

// File: tb/blk_xfer_seq_bench.sv
module blk_xfer_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_base = '0;
  logic [15:0] req_mask = '0;
  logic [1:0]  req_mode = '0;
  logic        req_load = 1'b0;
  logic        req_wb = 1'b0;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [3:0]  xfer_reg;
  logic [31:0] xfer_addr;
  logic        xfer_load;
  logic        fin_valid;
  logic [31:0] fin_base;
  logic        fin_wb_en;

  always #5 clk = ~clk;

  blk_xfer_seq u_blk_xfer_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_base(req_base),
    .req_mask(req_mask), .req_mode(req_mode), .req_load(req_load), .req_wb(req_wb),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_reg(xfer_reg),
    .xfer_addr(xfer_addr), .xfer_load(xfer_load),
    .fin_valid(fin_valid), .fin_base(fin_base), .fin_wb_en(fin_wb_en)
  );

  int checks = 0;
  int fails  = 0;
  int dones  = 0;
  bit finished = 1'b0;

  logic [3:0]  q_reg[$];
  logic [31:0] q_addr[$];
  logic        q_ld[$];
  string       q_tag[$];
  logic [31:0] q_fbase[$];
  logic        q_fwb[$];
  string       q_ftag[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory-side stall pattern
  logic [15:0] lfsr = 16'hACE1;
  bit full_rate = 1'b0;
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    xfer_ready = full_rate | lfsr[0] | lfsr[3];
  end

  // monitor
  bit          fin_due = 1'b0;
  bit          held = 1'b0;
  logic [3:0]  held_reg;
  logic [31:0] held_addr;
  always @(negedge clk) begin
    if (rst_n) begin
      if (fin_valid || fin_due)
        check(fin_valid == fin_due, "R9 strobe timing", 32'(fin_valid), 32'(fin_due));
      if (fin_valid) begin
        dones++;
        if (q_fbase.size() == 0) check(1'b0, "R9 unexpected strobe", 32'd1, 32'd0);
        else begin
          string t;
          logic [31:0] eb;
          logic ew;
          t = q_ftag.pop_front(); eb = q_fbase.pop_front(); ew = q_fwb.pop_front();
          check(fin_base == eb, t, fin_base, eb);
          check(fin_wb_en == ew, "R9 write-back enable", 32'(fin_wb_en), 32'(ew));
        end
      end
      fin_due = 1'b0;
      if (held)
        check(xfer_valid && xfer_reg == held_reg && xfer_addr == held_addr,
              "R8 stalled transfer moved", xfer_addr, held_addr);
      if (xfer_valid)
        check(!req_ready, "R1 ready while busy", 32'(req_ready), 32'd0);
      if (xfer_valid && xfer_ready) begin
        if (q_reg.size() == 0) check(1'b0, "R2 extra transfer", 32'(xfer_reg), 32'hFFFF_FFFF);
        else begin
          string t;
          logic [3:0] er;
          logic [31:0] ea;
          logic el;
          t = q_tag.pop_front(); er = q_reg.pop_front(); ea = q_addr.pop_front(); el = q_ld.pop_front();
          check(xfer_reg == er, "R2 register order", 32'(xfer_reg), 32'(er));
          check(xfer_addr == ea, t, xfer_addr, ea);
          check(xfer_load == el, "R10 direction", 32'(xfer_load), 32'(el));
          if (q_reg.size() == 0) fin_due = 1'b1;
        end
      end
      if (req_valid && req_ready && req_mask == 16'h0) fin_due = 1'b1;
      held = xfer_valid && !xfer_ready;
      held_reg = xfer_reg;
      held_addr = xfer_addr;
    end
  end

  task automatic run(input logic [31:0] base, input logic [15:0] mask, input logic [1:0] mode,
                     input logic ld, input logic wb, input string tag);
    int n;
    int k;
    logic [31:0] first;
    int target;
    n = $countones(mask);
    case (mode)
      2'd0: first = base;
      2'd1: first = base + 32'd4;
      2'd2: first = base - 32'(4 * n) + 32'd4;
      default: first = base - 32'(4 * n);
    endcase
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (mask[i]) begin
        q_reg.push_back(4'(i));
        q_addr.push_back(first + 32'(4 * k));
        q_ld.push_back(ld);
        q_tag.push_back(k == 0 ? tag : "R7 address step");
        k++;
      end
    end
    q_fbase.push_back(mode[1] ? base - 32'(4 * n) : base + 32'(4 * n));
    q_fwb.push_back(wb);
    q_ftag.push_back(n == 0 ? "R11 empty mask base" : "R9 new base");
    target = dones + 1;
    @(posedge clk); #2;
    while (!req_ready) begin @(posedge clk); #2; end
    req_base = base; req_mask = mask; req_mode = mode; req_load = ld; req_wb = wb;
    req_valid = 1'b1;
    @(posedge clk); #2;
    req_valid = 1'b0;
    while (dones < target) @(posedge clk);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'd1);
    check(xfer_valid == 1'b0, "R1 reset xfer_valid", 32'(xfer_valid), 32'd0);
    check(fin_valid == 1'b0, "R1 reset fin_valid", 32'(fin_valid), 32'd0);
    rst_n = 1'b1;
    run(32'h0000_1000, 16'h0F0F, 2'd0, 1'b1, 1'b1, "R3 first address");
    run(32'h0000_2000, 16'h8001, 2'd1, 1'b0, 1'b0, "R4 first address");
    run(32'h0000_3000, 16'h00F0, 2'd2, 1'b1, 1'b1, "R5 first address");
    run(32'h0000_4000, 16'hFFFF, 2'd3, 1'b0, 1'b1, "R6 first address");
    run(32'h0000_5000, 16'h0001, 2'd3, 1'b1, 1'b0, "R6 single register");
    run(32'h0000_5100, 16'h4000, 2'd2, 1'b0, 1'b1, "R5 single register");
    run(32'h0000_6000, 16'h0000, 2'd1, 1'b1, 1'b1, "R11 empty mask");
    run(32'hFFFF_FFF8, 16'h0007, 2'd0, 1'b1, 1'b1, "R12 wrap upward");
    run(32'h0000_0008, 16'h000F, 2'd3, 1'b0, 1'b1, "R12 wrap downward");
    full_rate = 1'b1;
    run(32'h0000_7000, 16'hA5A5, 2'd1, 1'b1, 1'b1, "R4 full rate");
    run(32'h0000_8000, 16'h5A5A, 2'd2, 1'b0, 1'b0, "R5 full rate");
    full_rate = 1'b0;
    repeat (4) @(posedge clk);
    check(q_reg.size() == 0, "R2 transfers outstanding", 32'(q_reg.size()), 32'd0);
    check(q_fbase.size() == 0, "R9 strobes outstanding", 32'(q_fbase.size()), 32'd0);
    finished = 1'b1;
    summary();
  end
endmodule